// File: doc/BRIEF.md
# SPI Master Frame Sequencer

This block is a single-channel serial master that shifts one frame of programmable length per start request. It pulls its active-low chip select low, waits a programmed setup interval, toggles the serial clock a fixed number of times while shifting a transmit word out and a receive word in, waits a programmed hold interval, releases chip select, and then keeps it released for a programmed minimum idle time before the next frame.

Clock polarity, clock phase, bit order, frame length and the four interval counts (half clock period, setup, hold, deselect) are sampled with each start strobe and held for the whole frame. A start strobe that arrives while a frame or its deselect interval is still running is held and launched as soon as the deselect interval ends. At the final clock edge of each frame the block publishes the received word, raises a sticky completion flag, raises a sticky end-of-queue flag if that frame was marked as the last of a queue, and steps a receive counter.

Top module: `spi_frame_master`

## Requirements
- R1: While reset is held, chip select (`pcs_n_o`) is high, `sck_o` and `sout_o` are 0, both flags are 0 and the receive counter is 0.
- R2: A frame starts by driving `pcs_n_o` low, and the first clock edge follows exactly max(setup_dly_i,1) system cycles later.
- R3: A frame of N bits (`frame_bits_i` = N, 1 to 16) toggles `sck_o` exactly 2N times, consecutive toggles max(half_period_i,1) cycles apart, and `sck_o` rests at the `cpol_i` level outside the toggling window.
- R4: With `cpha_i` = 0 the first bit is on `sout_o` when chip select falls, `sin_i` is sampled on odd edges and `sout_o` changes on even edges; with `cpha_i` = 1 `sout_o` changes on odd edges (the first bit at edge 1) and `sin_i` is sampled on even edges.
- R5: With `lsb_first_i` = 0 bits travel in both directions most significant first (bit N-1 of the word first); with 1, bit 0 first. The received word is right-aligned in `rx_word_o`.
- R6: Chip select rises exactly max(hold_dly_i,1) cycles after the last clock edge.
- R7: After chip select rises it stays high for at least max(gap_dly_i,1) cycles; a start strobe accepted during a frame is launched exactly that many cycles after the rise.
- R8: In the cycle of the final clock edge, `done_o` rises, `rx_count_o` increments by one and `rx_word_o` takes the received word; `eoq_o` rises in the same cycle when `eoq_i` was 1 with that frame's start.
- R9: The flags are sticky; a 1 on `clear_i[0]` clears `done_o` and a 1 on `clear_i[1]` clears `eoq_o` on the next edge, and a flag set in the same cycle as its clear stays set.
- R10: Frame lengths of 1 and of the maximum (16) bits behave as any other length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run a frame |
| eoq_i | input | 1 | Marks the requested frame as last of a queue |
| tx_word_i | input | 16 | Word to transmit, right-aligned |
| frame_bits_i | input | 5 | Frame length in bits (0 is taken as 1, above 16 as 16) |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | Clock phase select |
| lsb_first_i | input | 1 | 1 sends and receives bit 0 first |
| half_period_i | input | 8 | Serial clock half period in system cycles |
| setup_dly_i | input | 8 | Chip select to first edge interval |
| hold_dly_i | input | 8 | Last edge to chip select release interval |
| gap_dly_i | input | 8 | Minimum chip select high interval |
| clear_i | input | 2 | Write-one-to-clear: bit 0 completion, bit 1 end-of-queue |
| sin_i | input | 1 | Serial data from the slave |
| sck_o | output | 1 | Serial clock |
| sout_o | output | 1 | Serial data to the slave |
| pcs_n_o | output | 1 | Active-low chip select |
| rx_word_o | output | 16 | Last received word |
| done_o | output | 1 | Sticky transfer-complete flag |
| eoq_o | output | 1 | Sticky end-of-queue flag |
| rx_count_o | output | 8 | Count of completed frames |

## Verification
A wrong edge counter shows as a missing or extra `sck_o` toggle and as `done_o` rising at a different cycle than the last toggle, visible within one half period of the real frame end. A wrong interval counter load shifts the first toggle or the chip select rise by a whole number of cycles, measured directly from chip select. A wrong bit-index or phase decision corrupts the word captured by the bench's slave model or the word in `rx_word_o` at the end of that same frame, and a lost pending start shows as a stretched deselect gap on the very next frame.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_SHIFT = 3'd2,
        ST_HOLD  = 3'd3,
        ST_GAP   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/spi_interval_counter.sv
module spi_interval_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = (value_i == '0) ? '0 : value_i - W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // interval length drives R2, R3, R6, R7
    p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

endmodule

// File: rtl/spi_bit_index.sv
module spi_bit_index #(
    parameter int NW = 5
) (
    input  logic [NW-1:0] k_i,
    input  logic [NW-1:0] nbits_i,
    input  logic          lsb_i,
    output logic [NW-1:0] idx_o
);

    // position within the word of the k-th bit on the wire (R5)
    always_comb begin
        if (lsb_i) idx_o = k_i;
        else       idx_o = nbits_i - NW'(1) - k_i;
    end

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
    parameter int MAX_BITS = 16,
    parameter int DLY_W    = 8,
    parameter int CNT_W    = 8,
    localparam int NW      = $clog2(MAX_BITS + 1),
    localparam int EW      = NW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                eoq_i,
    input  logic [MAX_BITS-1:0] tx_word_i,
    input  logic [NW-1:0]       frame_bits_i,
    input  logic                cpol_i,
    input  logic                cpha_i,
    input  logic                lsb_first_i,
    input  logic [DLY_W-1:0]    half_period_i,
    input  logic [DLY_W-1:0]    setup_dly_i,
    input  logic [DLY_W-1:0]    hold_dly_i,
    input  logic [DLY_W-1:0]    gap_dly_i,
    input  logic [1:0]          clear_i,
    input  logic                sin_i,
    output logic                sck_o,
    output logic                sout_o,
    output logic                pcs_n_o,
    output logic [MAX_BITS-1:0] rx_word_o,
    output logic                done_o,
    output logic                eoq_o,
    output logic [CNT_W-1:0]    rx_count_o
);

    import spi_seq_pkg::*;

    typedef struct packed {
        logic [NW-1:0]    nbits;
        logic             cpol;
        logic             cpha;
        logic             lsb;
        logic             eoq;
        logic [DLY_W-1:0] half;
        logic [DLY_W-1:0] setup;
        logic [DLY_W-1:0] hold;
        logic [DLY_W-1:0] gap;
    } frame_cfg_t;

    typedef struct packed {
        seq_state_e          st;
        frame_cfg_t          cfg;
        logic [MAX_BITS-1:0] tx;
        logic [MAX_BITS-1:0] rx_acc;
        logic [MAX_BITS-1:0] rx_word;
        logic [EW-1:0]       edges;
        logic                sck;
        logic                sout;
        logic                pcs;
        logic                done;
        logic                eoq_f;
        logic [CNT_W-1:0]    rx_cnt;
        logic                pend;
        frame_cfg_t          pend_cfg;
        logic [MAX_BITS-1:0] pend_tx;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    frame_cfg_t          live_cfg, src_cfg;
    logic [MAX_BITS-1:0] src_tx;
    logic [NW-1:0]       live_bits;
    logic [EW-1:0]       edge_num, last_edge;
    logic [NW-1:0]       samp_k, drive_k;
    logic [NW-1:0]       first_idx, samp_idx, drive_idx;
    logic                ctr_zero, ctr_load, tick;
    logic [DLY_W-1:0]    ctr_val;

    // configuration presented with a start strobe, length clamped to 1..MAX_BITS
    assign live_bits = (frame_bits_i == '0)            ? NW'(1) :
                       (frame_bits_i > NW'(MAX_BITS))  ? NW'(MAX_BITS) : frame_bits_i;
    assign live_cfg  = '{nbits: live_bits, cpol: cpol_i, cpha: cpha_i, lsb: lsb_first_i,
                         eoq: eoq_i, half: half_period_i, setup: setup_dly_i,
                         hold: hold_dly_i, gap: gap_dly_i};
    assign src_cfg   = seq_q.pend ? seq_q.pend_cfg : live_cfg;
    assign src_tx    = seq_q.pend ? seq_q.pend_tx  : tx_word_i;

    // edge bookkeeping: edge_num is the number of the edge about to happen
    assign edge_num  = seq_q.edges + EW'(1);
    assign last_edge = {seq_q.cfg.nbits, 1'b0};
    assign samp_k    = seq_q.edges[EW-1:1];
    assign drive_k   = seq_q.cfg.cpha ? seq_q.edges[EW-1:1] : edge_num[EW-1:1];
    assign tick      = ctr_zero && (seq_q.st != ST_IDLE);

    spi_bit_index #(.NW(NW)) u_first_idx (
        .k_i(NW'(0)), .nbits_i(src_cfg.nbits), .lsb_i(src_cfg.lsb), .idx_o(first_idx)
    );
    spi_bit_index #(.NW(NW)) u_samp_idx (
        .k_i(samp_k), .nbits_i(seq_q.cfg.nbits), .lsb_i(seq_q.cfg.lsb), .idx_o(samp_idx)
    );
    spi_bit_index #(.NW(NW)) u_drive_idx (
        .k_i(drive_k), .nbits_i(seq_q.cfg.nbits), .lsb_i(seq_q.cfg.lsb), .idx_o(drive_idx)
    );

    spi_interval_counter #(.W(DLY_W)) u_interval (
        .clk(clk), .rst_n(rst_n), .load_i(ctr_load), .value_i(ctr_val), .zero_o(ctr_zero)
    );

    always_comb begin
        logic launch;
        seq_d    = seq_q;
        ctr_load = 1'b0;
        ctr_val  = '0;
        launch   = 1'b0;

        // write-one-to-clear; a set further down wins
        seq_d.done  = seq_q.done  & ~clear_i[0];
        seq_d.eoq_f = seq_q.eoq_f & ~clear_i[1];

        case (seq_q.st)
            ST_IDLE: begin
                seq_d.sck = cpol_i;
                if (start_i || seq_q.pend) launch = 1'b1;
            end
            ST_SETUP, ST_SHIFT: begin
                if (tick) begin
                    seq_d.edges = edge_num;
                    seq_d.sck   = ~seq_q.sck;
                    if (edge_num[0] != seq_q.cfg.cpha) begin
                        seq_d.rx_acc = seq_q.rx_acc | (MAX_BITS'(sin_i) << samp_idx);
                    end else if (edge_num < last_edge) begin
                        seq_d.sout = |((seq_q.tx >> drive_idx) & MAX_BITS'(1));
                    end
                    if (edge_num == last_edge) begin
                        seq_d.st      = ST_HOLD;
                        seq_d.done    = 1'b1;
                        seq_d.rx_cnt  = seq_q.rx_cnt + CNT_W'(1);
                        seq_d.rx_word = seq_d.rx_acc;
                        if (seq_q.cfg.eoq) seq_d.eoq_f = 1'b1;
                        ctr_load      = 1'b1;
                        ctr_val       = seq_q.cfg.hold;
                    end else begin
                        seq_d.st = ST_SHIFT;
                        ctr_load = 1'b1;
                        ctr_val  = seq_q.cfg.half;
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    seq_d.st   = ST_GAP;
                    seq_d.pcs  = 1'b1;
                    seq_d.sout = 1'b0;
                    ctr_load   = 1'b1;
                    ctr_val    = seq_q.cfg.gap;
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (start_i || seq_q.pend) launch = 1'b1;
                    else                      seq_d.st = ST_IDLE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase

        if (launch) begin
            seq_d.st     = ST_SETUP;
            seq_d.cfg    = src_cfg;
            seq_d.tx     = src_tx;
            seq_d.rx_acc = '0;
            seq_d.edges  = '0;
            seq_d.pcs    = 1'b0;
            seq_d.sck    = src_cfg.cpol;
            seq_d.sout   = src_cfg.cpha ? 1'b0 : |((src_tx >> first_idx) & MAX_BITS'(1));
            seq_d.pend   = 1'b0;
            ctr_load     = 1'b1;
            ctr_val      = src_cfg.setup;
        end

        // a strobe not consumed directly is parked until the sequencer is free
        if (start_i && !(launch && !seq_q.pend)) begin
            seq_d.pend     = 1'b1;
            seq_d.pend_cfg = live_cfg;
            seq_d.pend_tx  = tx_word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q     <= '0;
            seq_q.st  <= ST_IDLE;
            seq_q.pcs <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sck_o      = seq_q.sck;
    assign sout_o     = seq_q.sout;
    assign pcs_n_o    = seq_q.pcs;
    assign rx_word_o  = seq_q.rx_word;
    assign done_o     = seq_q.done;
    assign eoq_o      = seq_q.eoq_f;
    assign rx_count_o = seq_q.rx_cnt;

    p_pcs_fall_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_q.pcs) |-> (seq_q.st == ST_SETUP));

    p_setup_sck_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_SETUP && $past(seq_q.st) == ST_SETUP) |-> $stable(seq_q.sck));

    p_edge_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_SHIFT) |-> (seq_q.edges != '0 && seq_q.edges < {seq_q.cfg.nbits, 1'b0}));

    p_sck_rest_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_HOLD) |-> (seq_q.sck == seq_q.cfg.cpol));

    p_pcs_high_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE || seq_q.st == ST_GAP) |-> seq_q.pcs);

    p_done_final_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.done) |-> (seq_q.st == ST_HOLD && $past(seq_q.st) == ST_SHIFT));

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.rx_cnt != $past(seq_q.rx_cnt)) |->
            (seq_q.st == ST_HOLD && seq_q.rx_cnt == $past(seq_q.rx_cnt) + CNT_W'(1)));

endmodule

// File: tb/tb_spi_frame_master.sv
`timescale 1ns/1ps
module tb_spi_frame_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, eoq_i = 1'b0;
    logic [15:0] tx_word_i = '0;
    logic [4:0]  frame_bits_i = 5'd8;
    logic        cpol_i = 1'b0, cpha_i = 1'b0, lsb_first_i = 1'b0;
    logic [7:0]  half_period_i = 8'd1, setup_dly_i = 8'd1, hold_dly_i = 8'd1, gap_dly_i = 8'd1;
    logic [1:0]  clear_i = 2'b00;
    logic        slave_sin = 1'b0;
    logic        sck_o, sout_o, pcs_n_o, done_o, eoq_o;
    logic [15:0] rx_word_o;
    logic [7:0]  rx_count_o;

    always #5 clk = ~clk;

    spi_frame_master dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .eoq_i(eoq_i), .tx_word_i(tx_word_i),
        .frame_bits_i(frame_bits_i), .cpol_i(cpol_i), .cpha_i(cpha_i), .lsb_first_i(lsb_first_i),
        .half_period_i(half_period_i), .setup_dly_i(setup_dly_i), .hold_dly_i(hold_dly_i),
        .gap_dly_i(gap_dly_i), .clear_i(clear_i), .sin_i(slave_sin), .sck_o(sck_o),
        .sout_o(sout_o), .pcs_n_o(pcs_n_o), .rx_word_o(rx_word_o), .done_o(done_o),
        .eoq_o(eoq_o), .rx_count_o(rx_count_o)
    );

    typedef struct packed {
        logic [15:0] tx;
        logic [15:0] sw;
        logic [4:0]  n;
        logic        cpol;
        logic        cpha;
        logic        lsb;
        logic        eoq;
        logic [7:0]  h;
        logic [7:0]  s;
        logic [7:0]  a;
        logic [7:0]  g;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{16'h00A5, 16'h003C, 5'd8,  1'b0, 1'b0, 1'b0, 1'b0, 8'd2, 8'd3, 8'd2, 8'd2},
        '{16'h00A5, 16'h005A, 5'd8,  1'b0, 1'b1, 1'b0, 1'b1, 8'd1, 8'd1, 8'd1, 8'd1},
        '{16'h00B1, 16'h00C3, 5'd8,  1'b1, 1'b0, 1'b1, 1'b0, 8'd3, 8'd2, 8'd4, 8'd3},
        '{16'h1234, 16'hF00D, 5'd16, 1'b1, 1'b1, 1'b1, 1'b0, 8'd2, 8'd5, 8'd1, 8'd2},
        '{16'h0001, 16'h0001, 5'd1,  1'b0, 1'b1, 1'b0, 1'b0, 8'd1, 8'd0, 8'd0, 8'd0},
        '{16'h0000, 16'h0001, 5'd1,  1'b1, 1'b0, 1'b1, 1'b1, 8'd2, 8'd1, 8'd2, 8'd1},
        '{16'h002D, 16'h0015, 5'd6,  1'b0, 1'b0, 1'b1, 1'b0, 8'd1, 8'd4, 8'd3, 8'd5},
        '{16'hBEEF, 16'h8001, 5'd16, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 8'd1, 8'd1, 8'd1}
    };

    int checks = 0;
    int fails  = 0;

    // slave model configuration and observations
    int          s_n = 8;
    logic        s_lsb = 1'b0, s_cpha = 1'b0;
    logic [15:0] s_word = '0, s_cap = '0;
    int cyc = 0, edges = 0, t_fall = 0, t_first = 0, t_last = 0, t_rise = 0, t_done = 0, gap_meas = 0;
    logic pcs_prev = 1'b1, sck_prev = 1'b0, done_prev = 1'b0;

    function automatic int pos(input int k);
        return s_lsb ? k : (s_n - 1 - k);
    endfunction

    function automatic int at_least_one(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int word_mask(input int n);
        return (n >= 16) ? 32'hFFFF : ((1 << n) - 1);
    endfunction

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (pcs_prev && !pcs_n_o) begin
            gap_meas = cyc - t_rise;
            t_fall   = cyc;
            edges    = 0;
            s_cap    = '0;
            slave_sin = s_cpha ? 1'b0 : s_word[pos(0)];
        end else if (!pcs_prev && pcs_n_o) begin
            t_rise = cyc;
        end
        if (!pcs_prev && !pcs_n_o && sck_o != sck_prev) begin
            edges = edges + 1;
            if (edges == 1) t_first = cyc;
            t_last = cyc;
            if ((edges % 2 == 1) != s_cpha) begin
                s_cap[pos((edges - 1) / 2)] = sout_o;
            end else begin
                int k;
                k = s_cpha ? (edges - 1) / 2 : edges / 2;
                if (k < s_n) slave_sin = s_word[pos(k)];
            end
        end
        if (done_o && !done_prev) t_done = cyc;
        pcs_prev  = pcs_n_o;
        sck_prev  = sck_o;
        done_prev = done_o;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        tx_word_i = v.tx; frame_bits_i = v.n; cpol_i = v.cpol; cpha_i = v.cpha;
        lsb_first_i = v.lsb; eoq_i = v.eoq; half_period_i = v.h; setup_dly_i = v.s;
        hold_dly_i = v.a; gap_dly_i = v.g;
        s_n = int'(v.n); s_lsb = v.lsb; s_cpha = v.cpha; s_word = v.sw;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cnt0;
        repeat (3) tick();
        // R1 reset state
        chk("R1 pcs_n", int'(pcs_n_o), 1);
        chk("R1 sck", int'(sck_o), 0);
        chk("R1 sout", int'(sout_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 eoq", int'(eoq_o), 0);
        chk("R1 count", int'(rx_count_o), 0);
        rst_n = 1'b1;
        repeat (2) tick();

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = VECS[i];
            cnt0 = int'(rx_count_o);
            apply(v);
            start_i = 1'b1;
            tick();
            start_i = 1'b0;
            while (!done_o) tick();
            while (!pcs_n_o) tick();
            repeat (int'(v.g) + 3) tick();
            chk("R3 edge count", edges, 2 * int'(v.n));
            chk("R2 setup cycles", t_first - t_fall, at_least_one(int'(v.s)));
            chk("R3 edge span", t_last - t_first, (2 * int'(v.n) - 1) * at_least_one(int'(v.h)));
            chk("R6 hold cycles", t_rise - t_last, at_least_one(int'(v.a)));
            chk("R8 done at last edge", t_done, t_last);
            chk("R8 count step", int'(rx_count_o), (cnt0 + 1) % 256);
            chk("R8 eoq flag", int'(eoq_o), int'(v.eoq));
            chk("R4 rx word", int'(rx_word_o), int'(v.sw) & word_mask(int'(v.n)));
            chk("R5 slave capture", int'(s_cap), int'(v.tx) & word_mask(int'(v.n)));
            chk("R3 idle level", int'(sck_o), int'(v.cpol));
            if (v.n == 5'd1 || v.n == 5'd16) chk("R10 length edge", edges, 2 * int'(v.n));
            clear_i = 2'b11;
            tick();
            clear_i = 2'b00;
            chk("R9 done cleared", int'(done_o), 0);
            chk("R9 eoq cleared", int'(eoq_o), 0);
        end

        // R7: start parked during a frame launches exactly gap cycles after release
        begin
            vec_t p;
            p = '{16'h0096, 16'h0081, 5'd8, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2, 8'd2, 8'd2, 8'd4};
            cnt0 = int'(rx_count_o);
            apply(p);
            start_i = 1'b1;
            tick();
            start_i = 1'b0;
            repeat (4) tick();
            tx_word_i = 16'h005B;
            start_i = 1'b1;
            tick();
            start_i = 1'b0;
            while (int'(rx_count_o) != (cnt0 + 2) % 256) tick();
            while (!pcs_n_o) tick();
            repeat (8) tick();
            chk("R7 gap before parked frame", gap_meas, 4);
            chk("R7 parked frame word out", int'(s_cap), 16'h005B);
            chk("R7 parked frame word in", int'(rx_word_o), 16'h0081);
            chk("R8 two frames counted", int'(rx_count_o), (cnt0 + 2) % 256);
        end

        // R9: set wins over a clear in the same cycle, clear acts on the next edge
        begin
            vec_t c;
            c = '{16'h00C6, 16'h0039, 5'd8, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1, 8'd1, 8'd1, 8'd1};
            clear_i = 2'b11;
            tick();
            apply(c);
            start_i = 1'b1;
            tick();
            start_i = 1'b0;
            while (!done_o) tick();
            chk("R9 done set over clear", int'(done_o), 1);
            chk("R9 eoq set over clear", int'(eoq_o), 1);
            tick();
            chk("R9 done cleared next", int'(done_o), 0);
            chk("R9 eoq cleared next", int'(eoq_o), 0);
            clear_i = 2'b00;
            repeat (6) tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule